// File: doc/BRIEF.md
# Twiddle-Grouped Radix-2 FFT Address Generator

This block drives the data memory of an in-place, memory-based radix-2 decimation-in-frequency FFT engine of one fixed length. For every butterfly of every stage it produces the two memory locations that the butterfly reads and later writes back. The butterflies come out in an order where those sharing a twiddle factor are adjacent, which keeps the coefficient path from switching every cycle.

Internally a butterfly counter and a stage counter walk through all N/2 butterflies of each of the log2(N) stages. To form the addresses, the block places a 0 or a 1 above the butterfly counter's top bit and rotates that word right by the stage number, inside the address width. A `start` pulse launches a pass. Each cycle with `step` high consumes one butterfly, and `done` pulses once after the last butterfly of the last stage.

Top module: `fft_twgrp_agen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy` and `done` are 0 and `stage_idx` and `bfly_idx` are 0.
- R2: A `start` pulse while idle makes `busy` 1 from the next cycle, with `stage_idx` = 0 and `bfly_idx` = 0.
- R3: While `busy`, `addr_s` equals the LG-bit word {1'b0, `bfly_idx`} rotated right circularly by `stage_idx` bits, where LG = log2(N).
- R4: While `busy`, `addr_t` equals the LG-bit word {1'b1, `bfly_idx`} rotated right circularly by `stage_idx` bits.
- R5: While `busy`, each cycle with `step` high advances `bfly_idx` by one. When it passes N/2−1 it wraps to 0 and `stage_idx` increases by one. A cycle with `step` low leaves both unchanged.
- R6: The step that consumes butterfly N/2−1 of stage LG−1 makes `done` 1 for exactly the next cycle. In that same cycle `busy` is 0 and both indices are 0.
- R7: `start` has no effect while `busy`. The indices move only as R5 describes.
- R8: `step` has no effect while idle. `busy` stays 0 and the indices stay 0.
- R9: In every busy cycle, `addr_s` and `addr_t` differ in exactly bit LG−1−`stage_idx`, and that bit is 0 in `addr_s`. For N = 16 the pairs, as hex digits s then t, are: stage 0: 08 19 2A 3B 4C 5D 6E 7F; stage 1: 04 8C 15 9D 26 AE 37 BF; stage 2: 02 46 8A CE 13 57 9B DF; stage 3: 01 23 45 67 89 AB CD EF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when idle |
| step | input | 1 | Consumes the current butterfly |
| busy | output | 1 | A pass is in progress and the addresses are valid |
| done | output | 1 | One-cycle pulse after the final butterfly |
| stage_idx | output | SW | Current stage, 0 to LG−1 |
| bfly_idx | output | LG−1 | Current butterfly within the stage |
| addr_s | output | LG | Upper-leg memory address |
| addr_t | output | LG | Lower-leg memory address |

## Verification
The bench builds the block with N = 16. This gives four stages, so the rotator's amounts 0 through 3 each occur, including the full-width wrap where the inserted bit moves to the bottom. All 32 expected address pairs are listed literally, and the last stage's wrap into `done` is reached within a few dozen cycles. Step stalls, a `start` during a pass and steps while idle are applied at chosen points of that pass.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;

    typedef enum logic {
        AG_IDLE = 1'b0,
        AG_RUN  = 1'b1
    } ag_state_e;

    // per-cycle sequencing decisions
    typedef struct packed {
        logic adv;      // accepted step while running
        logic wrap_b;   // butterfly counter at its last value
        logic finish;   // last butterfly of last stage consumed
    } ag_ctl_t;

    function automatic int unsigned stage_bits(int unsigned lg);
        return (lg > 1) ? $clog2(lg) : 1;
    endfunction

endpackage

// File: rtl/agen_seq.sv
module agen_seq
    import fft_agen_pkg::*;
#(
    parameter int unsigned LG = 4,
    parameter int unsigned SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step,
    output logic          busy,
    output logic          done,
    output logic [LG-2:0] bfly,
    output logic [SW-1:0] stage
);
    localparam int unsigned   BW = LG - 1;
    localparam logic [SW-1:0] LAST_STAGE = SW'(LG - 1);

    ag_state_e state_q;
    logic      done_q;
    logic [BW-1:0] bfly_q;
    logic [SW-1:0] stage_q;
    ag_ctl_t   ctl;

    always_comb begin
        ctl.adv    = (state_q == AG_RUN) && step;
        ctl.wrap_b = (bfly_q == {BW{1'b1}});
        ctl.finish = ctl.adv && ctl.wrap_b && (stage_q == LAST_STAGE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= AG_IDLE;
            done_q  <= 1'b0;
            bfly_q  <= '0;
            stage_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                AG_IDLE: begin
                    if (start) begin
                        state_q <= AG_RUN;
                        bfly_q  <= '0;
                        stage_q <= '0;
                    end
                end
                AG_RUN: begin
                    if (ctl.finish) begin
                        state_q <= AG_IDLE;
                        done_q  <= 1'b1;
                        bfly_q  <= '0;
                        stage_q <= '0;
                    end else if (ctl.adv) begin
                        bfly_q <= bfly_q + 1'b1;
                        if (ctl.wrap_b)
                            stage_q <= stage_q + 1'b1;
                    end
                end
                default: state_q <= AG_IDLE;
            endcase
        end
    end

    assign busy  = (state_q == AG_RUN);
    assign done  = done_q;
    assign bfly  = bfly_q;
    assign stage = stage_q;

endmodule

// File: rtl/agen_rotr.sv
module agen_rotr #(
    parameter int unsigned W  = 4,
    parameter int unsigned KW = 2
) (
    input  logic [W-1:0]  din,
    input  logic [KW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] cand [W];

    for (genvar r = 0; r < W; r++) begin : g_cand
        if (r == 0) begin : g_zero
            assign cand[r] = din;
        end else begin : g_rot
            assign cand[r] = {din[r-1:0], din[W-1:r]};
        end
    end

    always_comb begin
        dout = din;
        for (int r = 0; r < int'(W); r++) begin
            if (amt == KW'(r))
                dout = cand[r];
        end
    end

endmodule

// File: rtl/fft_twgrp_agen.sv
module fft_twgrp_agen
    import fft_agen_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned LG = $clog2(N),
    parameter int unsigned SW = stage_bits(LG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step,
    output logic          busy,
    output logic          done,
    output logic [SW-1:0] stage_idx,
    output logic [LG-2:0] bfly_idx,
    output logic [LG-1:0] addr_s,
    output logic [LG-1:0] addr_t
);
    initial begin
        if ((N < 4) || ((N & (N - 1)) != 0))
            $error("N must be a power of two, at least 4");
    end

    logic [LG-2:0] bfly_w;
    logic [SW-1:0] stage_w;

    agen_seq #(.LG(LG), .SW(SW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .step  (step),
        .busy  (busy),
        .done  (done),
        .bfly  (bfly_w),
        .stage (stage_w)
    );

    agen_rotr #(.W(LG), .KW(SW)) u_rot_s (
        .din  ({1'b0, bfly_w}),
        .amt  (stage_w),
        .dout (addr_s)
    );

    agen_rotr #(.W(LG), .KW(SW)) u_rot_t (
        .din  ({1'b1, bfly_w}),
        .amt  (stage_w),
        .dout (addr_t)
    );

    assign stage_idx = stage_w;
    assign bfly_idx  = bfly_w;

endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
    parameter int unsigned LG = 4,
    parameter int unsigned SW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          step,
    input logic          busy,
    input logic          done,
    input logic [SW-1:0] stage_idx,
    input logic [LG-2:0] bfly_idx,
    input logic [LG-1:0] addr_s,
    input logic [LG-1:0] addr_t
);
    logic [LG-1:0] gap_bit;
    always_comb gap_bit = LG'(1) << (LG - 1 - int'(stage_idx));

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && bfly_idx == '0 && stage_idx == '0));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !step) |=> ($stable(bfly_idx) && $stable(stage_idx) && busy));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && bfly_idx == '0 && stage_idx == '0));

    // R8
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    // R9
    pair_gap_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (((addr_s ^ addr_t) == gap_bit) && ((addr_s & gap_bit) == '0)));

endmodule

bind fft_twgrp_agen agen_chk #(.LG(LG), .SW(SW)) u_agen_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .step      (step),
    .busy      (busy),
    .done      (done),
    .stage_idx (stage_idx),
    .bfly_idx  (bfly_idx),
    .addr_s    (addr_s),
    .addr_t    (addr_t)
);

// File: tb/test_fft_twgrp_agen.sv
module test_fft_twgrp_agen;
    localparam int unsigned N  = 16;
    localparam int unsigned LG = 4;
    localparam int unsigned SW = 2;

    // {s, t} per butterfly in generation order (R9)
    localparam logic [7:0] VEC [32] = '{
        8'h08, 8'h19, 8'h2A, 8'h3B, 8'h4C, 8'h5D, 8'h6E, 8'h7F,
        8'h04, 8'h8C, 8'h15, 8'h9D, 8'h26, 8'hAE, 8'h37, 8'hBF,
        8'h02, 8'h46, 8'h8A, 8'hCE, 8'h13, 8'h57, 8'h9B, 8'hDF,
        8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF
    };

    logic          clk = 1'b0;
    logic          rst, start, step;
    logic          busy, done;
    logic [SW-1:0] stage_idx;
    logic [LG-2:0] bfly_idx;
    logic [LG-1:0] addr_s, addr_t;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fft_twgrp_agen #(.N(N)) i_fft_twgrp_agen (
        .clk(clk), .rst(rst), .start(start), .step(step),
        .busy(busy), .done(done), .stage_idx(stage_idx), .bfly_idx(bfly_idx),
        .addr_s(addr_s), .addr_t(addr_t)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_vec(input int v, input string req);
        chk(addr_s == LG'(VEC[v] >> 4), {req, " R3 addr_s"}, int'(addr_s), int'(VEC[v] >> 4));
        chk(addr_t == LG'(VEC[v] & 8'h0F), {req, " R4 addr_t"}, int'(addr_t), int'(VEC[v] & 8'h0F));
        chk(stage_idx == SW'(v / 8), {req, " R5 stage"}, int'(stage_idx), v / 8);
        chk(bfly_idx == (LG-1)'(v % 8), {req, " R5 bfly"}, int'(bfly_idx), v % 8);
        chk(busy == 1'b1, {req, " R5 busy"}, int'(busy), 1);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; step = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(bfly_idx == '0 && stage_idx == '0, "R1 indices", int'({stage_idx, bfly_idx}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after release", int'(busy), 0);

        // R8 step while idle
        step = 1'b1;
        repeat (2) @(negedge clk);
        step = 1'b0;
        chk(busy == 1'b0, "R8 busy", int'(busy), 0);
        chk(bfly_idx == '0 && stage_idx == '0, "R8 indices", int'({stage_idx, bfly_idx}), 0);
        chk(done == 1'b0, "R8 done", int'(done), 0);

        // R2 launch
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        chk(bfly_idx == '0 && stage_idx == '0, "R2 indices", int'({stage_idx, bfly_idx}), 0);

        for (int v = 0; v < 32; v++) begin
            chk_vec(v, "table");
            if (v == 9) begin
                // R5 stall and R7 start while busy
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                @(negedge clk);
                chk_vec(v, "R7 stall+start");
            end
            step = 1'b1;
            if (v == 20) start = 1'b1;   // R7: start with step just advances
            @(negedge clk);
            step = 1'b0;
            start = 1'b0;
            if (v != 31) chk(done == 1'b0, "R6 no early done", int'(done), 0);
        end

        // R6 completion
        chk(done == 1'b1, "R6 done pulse", int'(done), 1);
        chk(busy == 1'b0, "R6 busy low", int'(busy), 0);
        chk(bfly_idx == '0 && stage_idx == '0, "R6 indices", int'({stage_idx, bfly_idx}), 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 single cycle", int'(done), 0);

        // R8 after a pass
        step = 1'b1;
        repeat (3) @(negedge clk);
        step = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R8 idle after pass", int'({busy, done}), 0);

        // second pass starts from the beginning
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_vec(0, "R2 relaunch");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule